// File: doc/BRIEF.md
# Configurable Product-Term Logic Block

This block is one programmable logic cell of a larger fabric. Eighteen logic inputs feed an array of product terms; every term's sensitivity to every input is set by configuration. Four macrocells each form one output from those terms. A macrocell either ORs four terms dedicated to it (the short path) or ORs any subset of the twenty shared terms and can XOR the result with one further term (the wide path). The result is driven out directly or through a flip-flop. Three further terms act as block controls: one can serve as the register clock, one clears the registers asynchronously, and one produces the output-enable level for the pads.

The register clock is chosen per block from three global clock inputs or from the clock term. Configuration arrives one bit at a time on a serial port under a program-enable strobe. Bits collect in a shadow register, and the active image is replaced only after the strobe is removed, so logic keeps running on the old function during a load. The loader is a three-state machine: `LD_IDLE` (no load), `LD_SHIFT` (bits entering), `LD_APPLY` (the shadow is copied into the active image). Its transitions are: idle to shift when `prog_en` is high; shift stays in shift while `prog_en` is high and goes to apply when it falls; apply goes to shift when `prog_en` is high again, otherwise back to idle.

Top module: `plb_cell`

## Requirements
- R1: Term t occupies configuration bits [36t+35:36t]; input i of that term uses bits [36t+2i+1:36t+2i], with code 01 = input true, 10 = input inverted, 00 or 11 = input ignored. The term is the AND of its non-ignored literals, and a term that ignores every input is 0. Terms 0 to 19 are shared, term 20 is the clock term, term 21 the clear term, term 22 the enable term.
- R2: Macrocell m on the short path (path bit 0) computes the OR of terms 4m to 4m+3.
- R3: Macrocell m on the wide path (path bit 1) computes the OR of the shared terms whose bit is set in its 20-bit mask, XORed with term 16+m when its XOR-enable bit is 1.
- R4: Macrocell m's 23 configuration bits start at bit 828+23m: [19:0] term mask, [20] XOR enable, [21] path select, [22] registered. With registered 0, `data_out[m]` follows the logic result; with registered 1 it shows the flip-flop, which holds between capture edges.
- R5: Bits [921:920] pick the register clock: 0, 1 and 2 select `gclk[0]`, `gclk[1]`, `gclk[2]`; 3 selects the clock term. Registers capture on a rising edge of the selected source only; edges on the other sources have no effect.
- R6: While the clear term is 1, every macrocell register is 0, independent of the clock, including when the clear and a clock edge arrive together.
- R7: While `rst_n` is low, all macrocell registers, the loader state and both configuration images are cleared, so every output and `oe_out` read 0 and stay 0 after release until a new image is loaded.
- R8: `oe_out` equals the enable term (term 22).
- R9: On each rising `cfg_clk` edge with `prog_en` high, `cfg_din` enters the shadow at bit 921 and the shadow moves one place toward bit 0, so the first of 922 bits sent ends at bit 0. The active image does not change while `prog_en` stays high.
- R10: After `prog_en` falls, the first rising `cfg_clk` edge moves the loader from shift to apply and the second copies the shadow into the active image; the old function stays visible until that second edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_clk | input | 1 | Configuration clock for the serial loader |
| rst_n | input | 1 | Global asynchronous clear, active low |
| prog_en | input | 1 | Program enable; high while configuration bits are shifted |
| cfg_din | input | 1 | Serial configuration data |
| gclk | input | 3 | Global clock sources for the macrocell registers |
| logic_in | input | 18 | Logic inputs to the product-term array |
| data_out | output | 4 | One output per macrocell |
| oe_out | output | 1 | Output-enable level from the enable term |

## Verification
The clear term and a rising edge of the selected register clock can occur in the same instant, and so can a clock-term edge and a change of the data it captures. The bench provokes the first case by raising the clear term's input and a global clock pulse in the same time step while the macrocell's data input is 1, and the output must read 0 afterwards. A second collision is a configuration load racing normal operation: outputs are sampled mid-load and on the edge after `prog_en` falls, where the old function must still hold, and one edge later, where the new one must appear.

// File: rtl/plb_pkg.sv
package plb_pkg;

    // number of global clock sources the block can pick from
    localparam int N_GCLK    = 3;
    // width of the clock-source field in the configuration image
    localparam int CSEL_W    = 2;
    // control terms placed after the shared pool
    localparam int N_CTRL_PT = 3;

    // two-bit literal codes of the AND array
    localparam logic [1:0] TC_TRUE = 2'b01;
    localparam logic [1:0] TC_COMP = 2'b10;

    typedef enum logic [1:0] {
        CK_G0 = 2'd0,
        CK_G1 = 2'd1,
        CK_G2 = 2'd2,
        CK_PT = 2'd3
    } clk_src_e;

    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_SHIFT = 2'd1,
        LD_APPLY = 2'd2
    } ld_state_e;

endpackage

// File: rtl/plb_cfg_loader.sv
module plb_cfg_loader
    import plb_pkg::*;
#(
    parameter int CFG_BITS = 922
) (
    input  logic                cfg_clk,
    input  logic                rst_n,
    input  logic                prog_en,
    input  logic                cfg_din,
    output logic [CFG_BITS-1:0] cfg_word,
    output logic [CFG_BITS-1:0] cfg_shadow
);

    ld_state_e state_q;
    ld_state_e state_n;
    logic      shift_en;
    logic      commit;

    // state register
    always_ff @(posedge cfg_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LD_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            LD_IDLE:  state_n = prog_en ? LD_SHIFT : LD_IDLE;
            LD_SHIFT: state_n = prog_en ? LD_SHIFT : LD_APPLY;
            LD_APPLY: state_n = prog_en ? LD_SHIFT : LD_IDLE;
            default:  state_n = LD_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        shift_en = prog_en;
        commit   = 1'b0;
        unique case (state_q)
            LD_IDLE:  commit = 1'b0;
            LD_SHIFT: commit = 1'b0;
            LD_APPLY: commit = 1'b1;
            default:  commit = 1'b0;
        endcase
    end

    // shadow image: new bit enters at the top end
    always_ff @(posedge cfg_clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_shadow <= '0;
        end else if (shift_en) begin
            cfg_shadow <= {cfg_din, cfg_shadow[CFG_BITS-1:1]};
        end
    end

    // active image, replaced only in the apply state
    always_ff @(posedge cfg_clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_word <= '0;
        end else if (commit) begin
            cfg_word <= cfg_shadow;
        end
    end

endmodule

// File: rtl/plb_and_array.sv
module plb_and_array
    import plb_pkg::*;
#(
    parameter int N_IN    = 18,
    parameter int N_TERMS = 23
) (
    input  logic [N_IN-1:0]           in_vec,
    input  logic [N_TERMS*2*N_IN-1:0] term_cfg,
    output logic [N_TERMS-1:0]        terms
);

    localparam int TERM_BITS = 2 * N_IN;

    for (genvar t = 0; t < N_TERMS; t++) begin : g_term
        logic [N_IN-1:0] lit;
        logic [N_IN-1:0] used;

        for (genvar i = 0; i < N_IN; i++) begin : g_in
            logic [1:0] code;
            assign code    = term_cfg[t*TERM_BITS + 2*i +: 2];
            assign used[i] = (code == TC_TRUE) || (code == TC_COMP);
            assign lit[i]  = (code == TC_TRUE) ? in_vec[i]  :
                             (code == TC_COMP) ? ~in_vec[i] : 1'b1;
        end

        // a term with no literal in use is forced low
        assign terms[t] = (&lit) & (|used);
    end

endmodule

// File: rtl/plb_macrocell.sv
module plb_macrocell #(
    parameter int N_PT  = 20,
    parameter int BYP_W = 4,
    parameter int N_MC  = 4,
    parameter int IDX   = 0
) (
    input  logic [N_PT-1:0] terms,
    input  logic [N_PT+2:0] mc_cfg,
    input  logic            sel_clk,
    input  logic            clr,
    output logic            mc_out,
    output logic            mc_q
);

    localparam int BYP_LO  = IDX * BYP_W;
    localparam int XOR_PT  = N_PT - N_MC + IDX;
    localparam int B_XEN   = N_PT;
    localparam int B_WIDE  = N_PT + 1;
    localparam int B_REG   = N_PT + 2;

    logic byp_or;
    logic wide_or;
    logic xor_op;
    logic wide_res;
    logic d_val;

    assign byp_or   = |terms[BYP_LO +: BYP_W];
    assign wide_or  = |(terms & mc_cfg[N_PT-1:0]);
    assign xor_op   = mc_cfg[B_XEN] & terms[XOR_PT];
    assign wide_res = wide_or ^ xor_op;
    assign d_val    = mc_cfg[B_WIDE] ? wide_res : byp_or;

    // clear dominates the clock
    always_ff @(posedge sel_clk or posedge clr) begin
        if (clr) begin
            mc_q <= 1'b0;
        end else begin
            mc_q <= d_val;
        end
    end

    assign mc_out = mc_cfg[B_REG] ? mc_q : d_val;

endmodule

// File: rtl/plb_cell.sv
module plb_cell
    import plb_pkg::*;
#(
    parameter int N_IN  = 18,
    parameter int N_PT  = 20,
    parameter int N_MC  = 4,
    parameter int BYP_W = 4
) (
    input  logic              cfg_clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic              cfg_din,
    input  logic [N_GCLK-1:0] gclk,
    input  logic [N_IN-1:0]   logic_in,
    output logic [N_MC-1:0]   data_out,
    output logic              oe_out
);

    localparam int TERM_BITS = 2 * N_IN;
    localparam int N_TERMS   = N_PT + N_CTRL_PT;
    localparam int PT_CLK    = N_PT;
    localparam int PT_RST    = N_PT + 1;
    localparam int PT_OE     = N_PT + 2;
    localparam int ARR_BITS  = N_TERMS * TERM_BITS;
    localparam int MC_BITS   = N_PT + 3;
    localparam int SEL_BASE  = ARR_BITS + N_MC * MC_BITS;
    localparam int CFG_BITS  = SEL_BASE + CSEL_W;

    logic [CFG_BITS-1:0] cfg_word;
    logic [CFG_BITS-1:0] cfg_shadow;
    logic [N_TERMS-1:0]  terms;
    logic [N_MC-1:0]     mc_q;
    logic                pt_rst;
    logic                mc_clr;
    logic                sel_clk;
    clk_src_e            clk_src;

    plb_cfg_loader #(
        .CFG_BITS (CFG_BITS)
    ) u_loader (
        .cfg_clk    (cfg_clk),
        .rst_n      (rst_n),
        .prog_en    (prog_en),
        .cfg_din    (cfg_din),
        .cfg_word   (cfg_word),
        .cfg_shadow (cfg_shadow)
    );

    plb_and_array #(
        .N_IN    (N_IN),
        .N_TERMS (N_TERMS)
    ) u_array (
        .in_vec   (logic_in),
        .term_cfg (cfg_word[ARR_BITS-1:0]),
        .terms    (terms)
    );

    // block clock selection
    assign clk_src = clk_src_e'(cfg_word[SEL_BASE +: CSEL_W]);

    always_comb begin
        sel_clk = 1'b0;
        unique case (clk_src)
            CK_G0:   sel_clk = gclk[0];
            CK_G1:   sel_clk = gclk[1];
            CK_G2:   sel_clk = gclk[2];
            CK_PT:   sel_clk = terms[PT_CLK];
            default: sel_clk = 1'b0;
        endcase
    end

    assign pt_rst = terms[PT_RST];
    assign mc_clr = pt_rst | ~rst_n;
    assign oe_out = terms[PT_OE];

    for (genvar m = 0; m < N_MC; m++) begin : g_mc
        plb_macrocell #(
            .N_PT  (N_PT),
            .BYP_W (BYP_W),
            .N_MC  (N_MC),
            .IDX   (m)
        ) u_mc (
            .terms   (terms[N_PT-1:0]),
            .mc_cfg  (cfg_word[ARR_BITS + m*MC_BITS +: MC_BITS]),
            .sel_clk (sel_clk),
            .clr     (mc_clr),
            .mc_out  (data_out[m]),
            .mc_q    (mc_q[m])
        );
    end

endmodule

// File: rtl/plb_cell_chk.sv
module plb_cell_chk #(
    parameter int CFG_BITS = 922,
    parameter int N_MC     = 4
) (
    input logic                cfg_clk,
    input logic                rst_n,
    input logic                prog_en,
    input logic [CFG_BITS-1:0] cfg_word,
    input logic [CFG_BITS-1:0] cfg_shadow,
    input logic                pt_rst,
    input logic [N_MC-1:0]     mc_q
);

    // R9: active image frozen while loading continues
    assert_cfg_hold_R9: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (prog_en && $past(prog_en)) |=> $stable(cfg_word));

    // R10: image copied from the shadow on the second edge after prog_en falls
    assert_apply_copy_R10: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (!prog_en && $past(prog_en)) |=> ##1 (cfg_word == $past(cfg_shadow)));

    // R10: no further copy once the loader has settled in idle
    assert_cfg_idle_R10: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (!prog_en && !$past(prog_en) && !$past(prog_en, 2)) |=> $stable(cfg_word));

    // R6: a held clear term keeps every register at zero
    assert_pt_clear_R6: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (pt_rst && $past(pt_rst)) |-> (mc_q == '0));

endmodule

bind plb_cell plb_cell_chk #(
    .CFG_BITS (CFG_BITS),
    .N_MC     (N_MC)
) u_chk (
    .cfg_clk    (cfg_clk),
    .rst_n      (rst_n),
    .prog_en    (prog_en),
    .cfg_word   (cfg_word),
    .cfg_shadow (cfg_shadow),
    .pt_rst     (pt_rst),
    .mc_q       (mc_q)
);

// File: tb/plb_cell_tb.sv
module plb_cell_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N_IN       = 18;
    localparam int N_PT       = 20;
    localparam int N_MC       = 4;
    localparam int TB_BITS    = 2 * N_IN;
    localparam int N_TERMS    = N_PT + 3;
    localparam int MC_BASE    = N_TERMS * TB_BITS;
    localparam int MCB        = N_PT + 3;
    localparam int SEL_BASE   = MC_BASE + N_MC * MCB;
    localparam int CFG_BITS   = SEL_BASE + 2;
    localparam int WD_CYCLES  = 60000;
    localparam int N_VEC      = 7;

    // {logic_in[17:0], oe_out, data_out[3:0]} for image A (all combinatorial)
    localparam logic [22:0] VEC [N_VEC] = '{
        {18'h00000, 5'b0_1001},
        {18'h3FFFF, 5'b1_1101},
        {18'h00107, 5'b0_0001},
        {18'h0090C, 5'b1_0010},
        {18'h10554, 5'b0_1000},
        {18'h30174, 5'b0_0110},
        {18'h00200, 5'b0_1001}
    };

    logic                cfg_clk = 1'b0;
    logic                rst_n;
    logic                prog_en;
    logic                cfg_din;
    logic [2:0]          gclk;
    logic [N_IN-1:0]     logic_in;
    logic [N_MC-1:0]     data_out;
    logic                oe_out;
    logic [CFG_BITS-1:0] cfg_img;
    int                  n_chk  = 0;
    int                  n_fail = 0;

    plb_cell u_dut (
        .cfg_clk  (cfg_clk),
        .rst_n    (rst_n),
        .prog_en  (prog_en),
        .cfg_din  (cfg_din),
        .gclk     (gclk),
        .logic_in (logic_in),
        .data_out (data_out),
        .oe_out   (oe_out)
    );

    always #(CLK_PERIOD/2) cfg_clk = ~cfg_clk;

    task automatic chk(input string req, input logic [4:0] exp);
        logic [4:0] act;
        act = {oe_out, data_out};
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic set_lit(input int t, input int i, input logic [1:0] code);
        cfg_img[t*TB_BITS + 2*i +: 2] = code;
    endtask

    task automatic set_mc(input int m, input logic [N_PT-1:0] mask,
                          input logic xen, input logic wide, input logic regd);
        cfg_img[MC_BASE + m*MCB +: MCB] = {regd, wide, xen, mask};
    endtask

    task automatic build_a();
        cfg_img = '0;
        set_lit(0, 0, 2'b01);  set_lit(0, 1, 2'b01);
        set_lit(1, 2, 2'b10);
        set_lit(8, 3, 2'b01);
        set_lit(9, 4, 2'b01);  set_lit(9, 5, 2'b10);
        set_lit(14, 9, 2'b11); set_lit(14, 10, 2'b01);
        set_lit(15, 8, 2'b10);
        set_lit(17, 6, 2'b01);
        set_lit(18, 16, 2'b01); set_lit(18, 17, 2'b01);
        set_lit(22, 11, 2'b01);
        set_mc(0, '0, 1'b0, 1'b0, 1'b0);
        set_mc(1, (N_PT'(1) << 8) | (N_PT'(1) << 9), 1'b1, 1'b1, 1'b0);
        set_mc(2, '0, 1'b1, 1'b1, 1'b0);
        set_mc(3, '0, 1'b0, 1'b0, 1'b0);
        cfg_img[SEL_BASE +: 2] = 2'd0;
    endtask

    task automatic build_b(input logic [1:0] sel);
        cfg_img = '0;
        set_lit(0, 0, 2'b01);
        set_lit(8, 3, 2'b01);
        set_lit(20, 13, 2'b01);
        set_lit(21, 12, 2'b01);
        set_mc(0, '0, 1'b0, 1'b0, 1'b1);
        set_mc(1, N_PT'(1) << 8, 1'b0, 1'b1, 1'b1);
        set_mc(2, '0, 1'b0, 1'b0, 1'b0);
        set_mc(3, '0, 1'b0, 1'b1, 1'b0);
        cfg_img[SEL_BASE +: 2] = sel;
    endtask

    task automatic load_cfg(input bit probe, input logic [4:0] old_exp,
                            input logic [4:0] new_exp);
        for (int i = 0; i < CFG_BITS; i++) begin
            @(negedge cfg_clk);
            prog_en = 1'b1;
            cfg_din = cfg_img[i];
            if (probe && i == CFG_BITS/2) begin
                #1 chk("R9 mid-load keeps old function", old_exp);
            end
        end
        @(negedge cfg_clk);
        prog_en = 1'b0;
        cfg_din = 1'b0;
        @(negedge cfg_clk);
        if (probe) begin
            #1 chk("R10 first edge after strobe keeps old function", old_exp);
        end
        @(negedge cfg_clk);
        if (probe) begin
            #1 chk("R10 second edge applies new image", new_exp);
        end
    endtask

    task automatic pulse(input int k);
        gclk[k] = 1'b1;
        #1;
        gclk[k] = 1'b0;
        #1;
    endtask

    task automatic drive(input logic [N_IN-1:0] v);
        logic_in = v;
        #1;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge cfg_clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n    = 1'b1;
        prog_en  = 1'b0;
        cfg_din  = 1'b0;
        gclk     = '0;
        logic_in = '0;
        cfg_img  = '0;
        #1 rst_n = 1'b0;
        repeat (3) @(negedge cfg_clk);
        chk("R7 reset state", 5'b0_0000);
        rst_n = 1'b1;

        // image A: term codes, short and wide paths, enable term
        build_a();
        load_cfg(1'b0, '0, '0);
        for (int v = 0; v < N_VEC; v++) begin
            drive(VEC[v][22:5]);
            chk($sformatf("R1 R2 R3 R4 R8 vector %0d", v), VEC[v][4:0]);
        end

        // load image B while image A is live
        drive(18'h00009);
        build_b(2'd1);
        load_cfg(1'b1, 5'b0_1011, 5'b0_0100);

        // register capture on the selected global clock only
        pulse(0);
        chk("R5 unselected gclk0 ignored", 5'b0_0100);
        pulse(2);
        chk("R5 unselected gclk2 ignored", 5'b0_0100);
        pulse(1);
        chk("R5 R4 capture on gclk1", 5'b0_0111);
        drive(18'h00000);
        chk("R4 registered outputs hold", 5'b0_0011);
        pulse(1);
        chk("R4 capture zero", 5'b0_0000);

        // clear term
        drive(18'h00009);
        pulse(1);
        chk("R5 recapture", 5'b0_0111);
        drive(18'h01009);
        chk("R6 clear term clears registers", 5'b0_0100);
        pulse(1);
        chk("R6 clear beats clock edge", 5'b0_0100);
        drive(18'h00009);
        chk("R6 registers stay clear after release", 5'b0_0100);
        pulse(1);
        chk("R5 capture after clear", 5'b0_0111);
        logic_in = 18'h01009;
        gclk[1]  = 1'b1;
        #1;
        gclk[1]  = 1'b0;
        #1;
        chk("R6 clear and clock in same instant", 5'b0_0100);
        drive(18'h00009);
        chk("R6 release after collision", 5'b0_0100);

        // clock term as register clock
        build_b(2'd3);
        load_cfg(1'b0, '0, '0);
        chk("R10 reload with clock term", 5'b0_0100);
        pulse(1);
        chk("R5 gclk1 ignored with clock term", 5'b0_0100);
        drive(18'h02009);
        chk("R5 clock term rising edge captures", 5'b0_0111);
        drive(18'h00000);
        chk("R5 clock term falling edge holds", 5'b0_0011);
        drive(18'h02000);
        chk("R5 clock term captures zero", 5'b0_0000);
        drive(18'h00009);
        drive(18'h02009);
        chk("R5 clock term captures again", 5'b0_0111);

        // global reset
        @(negedge cfg_clk);
        rst_n = 1'b0;
        #1 chk("R7 global reset clears", 5'b0_0000);
        @(negedge cfg_clk);
        rst_n = 1'b1;
        drive(18'h3FFFF);
        chk("R7 image cleared by reset", 5'b0_0000);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule